// File: doc/BRIEF.md
# Interpolated Inverse-Square-Root Seed Table

This block supplies the starting estimate of 1/sqrt(x) that a Newton-Raphson refinement unit needs for a single-precision mantissa. A caller presents an 11-bit index, formed from the leading operand bits, together with a request strobe. Two clock cycles later the block returns a 23-bit seed word and a matching valid strobe. A new request may be accepted on every cycle.

The 2048-word logical table is never stored at full size. The storage holds only the 1024 even-index points, and each of them keeps only its low 20 bits. For every word, the top three bits are rebuilt from the index through a constant bit and two fixed comparisons. A request for an odd index returns the truncated mean of the two rebuilt even neighbours. The topmost odd index has no upper neighbour, so it returns its lower neighbour unchanged. Stage one reads both neighbours and classifies the request. Stage two rebuilds the full words and selects or blends them.

Top module: `seed_rsqrt_table`

## Requirements
- R1: While reset is held and in the first cycle after it, valid_out is 0 and seed_out is 0.
- R2: valid_out is 1 exactly two clock cycles after a cycle in which valid_in was sampled as 1, and 0 otherwise. Requests on consecutive cycles are all served.
- R3: Bit 22 (the MSB) of every valid seed_out is 1.
- R4: For an even index a, bit 21 of the seed is 1 when a <= 1593 and 0 when a > 1593.
- R5: For an even index a, bit 20 of the seed is 1 when a <= 627. Otherwise it is the inverse of bit 21.
- R6: For an even index a, bits 19..0 of the seed equal 1048575 - 1023*(a/2).
- R7: For an odd index a below 2047, the seed is floor((W(a-1) + W(a+1)) / 2). W is the full 23-bit even-index word defined by R3 to R6.
- R8: For index 2047 the seed equals W(2046).
- R9: seed_out keeps its last valid value in every cycle where valid_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Request strobe |
| addr_in | input | 11 | Table index |
| valid_out | output | 1 | Result strobe, two cycles after the request |
| seed_out | output | 23 | Seed word |

## Verification
The assertions assume the following about the inputs:
- reset is asserted from time zero;
- valid_in and addr_in always hold defined values;
- addr_in changes only away from the rising clock edge.

The stimulus keeps to these assumptions. It drives every input on the falling edge, holds reset through the first cycles, and draws indices over the whole 0 to 2047 range.

On top of the random traffic, directed requests hit the comparison edges at 627/628 and 1593/1594 and the odd indices that straddle them, because there the two averaged neighbours differ in their rebuilt bits. They also hit the last even index and the top index 2047.

// File: rtl/seed_pkg.sv
package seed_pkg;
    parameter int ADDR_W      = 11;
    parameter int SEED_W      = 23;
    parameter int REBUILT_W   = 3;
    parameter int HI_LIMIT    = 1593;
    parameter int MID_LIMIT   = 627;
    parameter int LOW_STEP    = 1023;

    localparam int STORE_W     = SEED_W - REBUILT_W;
    localparam int IDX_W       = ADDR_W - 1;
    localparam int LAST_IDX    = (1 << IDX_W) - 1;

    typedef enum logic [1:0] {
        PICK_EVEN = 2'd0,
        PICK_MID  = 2'd1,
        PICK_TOP  = 2'd2
    } pick_e;

    function automatic logic [STORE_W-1:0] stored_low(input logic [IDX_W-1:0] idx);
        logic [STORE_W-1:0] prod;
        prod = STORE_W'(idx) * STORE_W'(LOW_STEP);
        return {STORE_W{1'b1}} - prod;
    endfunction
endpackage

// File: rtl/seed_rebuild.sv
module seed_rebuild
    import seed_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    output logic [REBUILT_W-1:0] top
);
    logic hi_bit;
    logic mid_bit;

    always_comb begin
        hi_bit  = (addr <= ADDR_W'(HI_LIMIT));
        mid_bit = (addr <= ADDR_W'(MID_LIMIT)) ? 1'b1 : ~hi_bit;
        top     = {1'b1, hi_bit, mid_bit};
    end
endmodule

// File: rtl/seed_fetch.sv
module seed_fetch
    import seed_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [ADDR_W-1:0]   addr_in,
    output logic                s1_valid,
    output pick_e               s1_pick,
    output logic [ADDR_W-1:0]   s1_lo_addr,
    output logic [ADDR_W-1:0]   s1_hi_addr,
    output logic [STORE_W-1:0]  s1_lo_low,
    output logic [STORE_W-1:0]  s1_hi_low
);
    logic [IDX_W-1:0]   lo_idx;
    logic [IDX_W-1:0]   hi_idx;
    logic               is_last;
    pick_e              pick_nxt;

    always_comb begin
        lo_idx  = addr_in[ADDR_W-1:1];
        is_last = (lo_idx == IDX_W'(LAST_IDX));
        hi_idx  = is_last ? lo_idx : lo_idx + 1'b1;
        if (!addr_in[0])
            pick_nxt = PICK_EVEN;
        else if (is_last)
            pick_nxt = PICK_TOP;
        else
            pick_nxt = PICK_MID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_pick    <= PICK_EVEN;
            s1_lo_addr <= '0;
            s1_hi_addr <= '0;
            s1_lo_low  <= '0;
            s1_hi_low  <= '0;
        end else begin
            s1_valid <= valid_in;
            if (valid_in) begin
                s1_pick    <= pick_nxt;
                s1_lo_addr <= {lo_idx, 1'b0};
                s1_hi_addr <= {hi_idx, 1'b0};
                s1_lo_low  <= stored_low(lo_idx);
                s1_hi_low  <= stored_low(hi_idx);
            end
        end
    end
endmodule

// File: rtl/seed_blend.sv
module seed_blend
    import seed_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s1_valid,
    input  pick_e               s1_pick,
    input  logic [SEED_W-1:0]   lo_word,
    input  logic [SEED_W-1:0]   hi_word,
    output logic                valid_out,
    output logic [SEED_W-1:0]   seed_out
);
    logic [SEED_W:0]     pair_sum;
    logic [SEED_W-1:0]   seed_nxt;

    always_comb begin
        pair_sum = {1'b0, lo_word} + {1'b0, hi_word};
        unique case (s1_pick)
            PICK_EVEN: seed_nxt = lo_word;
            PICK_MID:  seed_nxt = pair_sum[SEED_W:1];
            PICK_TOP:  seed_nxt = lo_word;
            default:   seed_nxt = lo_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            seed_out  <= '0;
        end else begin
            valid_out <= s1_valid;
            if (s1_valid)
                seed_out <= seed_nxt;
        end
    end
endmodule

// File: rtl/seed_rsqrt_table.sv
module seed_rsqrt_table
    import seed_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [ADDR_W-1:0]   addr_in,
    output logic                valid_out,
    output logic [SEED_W-1:0]   seed_out
);
    logic                 s1_valid;
    pick_e                s1_pick;
    logic [ADDR_W-1:0]    s1_lo_addr;
    logic [ADDR_W-1:0]    s1_hi_addr;
    logic [STORE_W-1:0]   s1_lo_low;
    logic [STORE_W-1:0]   s1_hi_low;
    logic [ADDR_W-1:0]    pair_addr [2];
    logic [REBUILT_W-1:0] pair_top  [2];
    logic [SEED_W-1:0]    lo_word;
    logic [SEED_W-1:0]    hi_word;

    seed_fetch u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_in   (valid_in),
        .addr_in    (addr_in),
        .s1_valid   (s1_valid),
        .s1_pick    (s1_pick),
        .s1_lo_addr (s1_lo_addr),
        .s1_hi_addr (s1_hi_addr),
        .s1_lo_low  (s1_lo_low),
        .s1_hi_low  (s1_hi_low)
    );

    assign pair_addr[0] = s1_lo_addr;
    assign pair_addr[1] = s1_hi_addr;

    for (genvar g = 0; g < 2; g++) begin : g_rebuild
        seed_rebuild u_rebuild (
            .addr (pair_addr[g]),
            .top  (pair_top[g])
        );
    end

    assign lo_word = {pair_top[0], s1_lo_low};
    assign hi_word = {pair_top[1], s1_hi_low};

    seed_blend u_blend (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_pick   (s1_pick),
        .lo_word   (lo_word),
        .hi_word   (hi_word),
        .valid_out (valid_out),
        .seed_out  (seed_out)
    );
endmodule

// File: rtl/seed_rsqrt_table_chk.sv
module seed_rsqrt_table_chk
    import seed_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                valid_in,
    input logic [ADDR_W-1:0]   addr_in,
    input logic                valid_out,
    input logic [SEED_W-1:0]   seed_out
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> ##1 valid_out); // R2

    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> ##1 !valid_out); // R2

    AST_MSB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> seed_out[SEED_W-1]); // R3

    AST_HI_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !addr_in[0]) |=> ##1
        (seed_out[SEED_W-2] == ($past(addr_in, 2) <= ADDR_W'(HI_LIMIT)))); // R4

    AST_MID_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !addr_in[0]) |=> ##1
        (seed_out[SEED_W-3] == (($past(addr_in, 2) <= ADDR_W'(MID_LIMIT)) ||
                                ($past(addr_in, 2) >  ADDR_W'(HI_LIMIT))))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_out |-> $stable(seed_out)); // R9
endmodule

bind seed_rsqrt_table seed_rsqrt_table_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .addr_in   (addr_in),
    .valid_out (valid_out),
    .seed_out  (seed_out)
);

// File: tb/tb_seed_rsqrt_table.sv
`timescale 1ns/1ps
module tb_seed_rsqrt_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [10:0] addr_in = '0;
    logic        valid_out;
    logic [22:0] seed_out;

    int checks = 0;
    int bad = 0;
    bit hist_v [2];
    int hist_a [2];
    logic [22:0] last_seed = '0;

    always #10 clk = ~clk;

    seed_rsqrt_table dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
        .addr_in(addr_in), .valid_out(valid_out), .seed_out(seed_out)
    );

    function automatic int unsigned even_word(int a);
        int unsigned hb, mb;
        hb = (a <= 1593) ? 1 : 0;
        mb = (a <= 627) ? 1 : (hb ^ 1);
        return (4 << 20) | (hb << 21) | (mb << 20) | (1048575 - 1023 * (a / 2));
    endfunction

    function automatic int unsigned expect_word(int a);
        if (a % 2 == 0) return even_word(a);
        if (a == 2047) return even_word(2046);
        return (even_word(a - 1) + even_word(a + 1)) >> 1;
    endfunction

    task automatic check(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, int a);
        int unsigned e;
        @(negedge clk);
        check("R2 valid_out", valid_out, hist_v[1]);
        if (hist_v[1]) begin
            e = expect_word(hist_a[1]);
            check("R3 msb", seed_out[22], 1);
            if (hist_a[1] == 2047)
                check("R8 top index", seed_out, e);
            else if (hist_a[1] % 2 == 1)
                check("R7 odd mean", seed_out, e);
            else begin
                check("R4 bit21", seed_out[21], e[21]);
                check("R5 bit20", seed_out[20], e[20]);
                check("R6 low bits", seed_out[19:0], e[19:0]);
            end
            last_seed = seed_out;
        end else begin
            check("R9 hold", seed_out, last_seed);
        end
        hist_v[1] = hist_v[0];
        hist_a[1] = hist_a[0];
        hist_v[0] = v;
        hist_a[0] = a;
        valid_in = v;
        addr_in = 11'(a);
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int directed [16] = '{0, 1, 2, 626, 627, 628, 629, 1592,
                              1593, 1594, 1595, 1596, 2044, 2045, 2046, 2047};
        void'($urandom(32'd1234));
        hist_v[0] = 0; hist_v[1] = 0; hist_a[0] = 0; hist_a[1] = 0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", valid_out, 0);
        check("R1 reset seed", seed_out, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset valid", valid_out, 0);
        check("R1 post-reset seed", seed_out, 0);
        for (int i = 0; i < 16; i++) step(1'b1, directed[i]);
        for (int i = 0; i < 16; i++) begin
            step(1'b1, directed[15 - i]);
            step(1'b0, 0);
        end
        for (int i = 0; i < 400; i++)
            step(($urandom % 10) < 7, int'($urandom % 2048));
        step(1'b0, 0);
        step(1'b0, 0);
        step(1'b0, 0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule